// File: doc/BRIEF.md
# Camera Pixel Capture and Format Expander

This block sits directly on a parallel camera port and runs on the camera's pixel clock. While the line-valid input is high, it takes one byte from the 8-bit data bus on every rising clock edge and pairs consecutive bytes into one packed 16-bit pixel. A 3-bit run-time selector picks the packed layout, which is 4:4:4, 5:5:5 or 5:6:5 RGB. The block widens each colour component to 8 bits by left-justifying it and filling the low bits with zeros. No arithmetic scaling is applied.

The result is a 32-bit word with the 24-bit colour in its low bits, a one-cycle valid strobe, and two markers. A start-of-frame marker is raised on the first pixel after a vertical-sync pulse. An end-of-line marker is raised on the last pixel of each line. A video stream bridge downstream can use these markers as its frame-start and line-end flags. Each assembled pixel is held for one pixel period. This is what lets the end-of-line marker be attached to the last pixel once the line-valid input drops.

Top module: `cam_pix_capture`

## Requirements
- R1: While rst_n is low, pix_valid, pix_sof and pix_eol are 0 and pix_word is all zeros.
- R2: Bytes are taken only on rising pclk edges where href is high. Every two such bytes form one pixel, and the first byte of the pair is the high half of the 16-bit value.
- R3: With fmt_sel 010, and with any reserved code 011 to 111, the 16-bit value is read as red[15:11], green[10:5], blue[4:0]. It expands to {r,3'b0}, {g,2'b0}, {b,3'b0}.
- R4: With fmt_sel 001, the value is read as red[14:10], green[9:5], blue[4:0], and each component expands to {c,3'b0}. Bit 15 has no effect.
- R5: With fmt_sel 000, the value is read as red[11:8], green[7:4], blue[3:0], and each component expands to {c,4'b0}. Bits 15:12 have no effect.
- R6: pix_word carries red in [23:16], green in [15:8] and blue in [7:0]. Bits [31:24] are always zero.
- R7: pix_sof is set on the first pixel completed after the block has sampled vsync high and then low, and on no other pixel. No pixel completed after reset and before such a pulse carries it.
- R8: The last pixel of a line appears with pix_eol set in the cycle after the first rising edge that samples href low.
- R9: A pixel that is not the last of its line appears, without pix_eol, in the cycle after the edge that samples the second byte of the following pixel.
- R10: A trailing odd byte at the end of a line produces no pixel. Pairing restarts at every rising edge of href, so the first byte of each line is always a high byte.
- R11: pix_valid is a strobe of one cycle per pixel. pix_sof and pix_eol are never high without pix_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Camera pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Vertical sync from the camera, high between frames |
| href | input | 1 | Line-valid; data bytes are valid while high |
| cam_d | input | 8 | Camera data byte |
| fmt_sel | input | 3 | Packed pixel layout: 000 4:4:4, 001 5:5:5, 010 5:6:5 |
| pix_word | output | 32 | Expanded pixel, RGB888 in [23:0], zero in [31:24] |
| pix_valid | output | 1 | One-cycle strobe for pix_word |
| pix_sof | output | 1 | Start-of-frame marker on the first pixel of a frame |
| pix_eol | output | 1 | End-of-line marker on the last pixel of a line |

## Verification
The bench goes after the line edges.

- **Short and odd lines.** A line of one byte must produce nothing. A line of three or five bytes must drop its last byte. A design that kept a stale pairing phase would pair across lines, or emit a pixel built from a leftover byte.
- **Single-pixel line.** A line of exactly two bytes must give one pixel carrying both markers. A design that emitted the held pixel too early would lose pix_eol, or duplicate the pixel.
- **Unused high bits.** The 5:5:5 and 4:4:4 layouts are fed with those bits set. A wrong shift shows up as a changed colour.
- **Start-of-frame placement.** The first line after reset has no frame marker. Every marker is expected exactly one pixel after a vsync pulse, so a design that armed at reset or on every line would be caught.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  localparam int BYTE_W = 8;
  localparam int CH_W   = 8;
  localparam int WORD_W = 32;
  localparam int PAIR_W = 2 * BYTE_W;

  localparam logic [2:0] FMT_444 = 3'b000;
  localparam logic [2:0] FMT_555 = 3'b001;
  localparam logic [2:0] FMT_565 = 3'b010;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // Left-justify a packed 16-bit pixel into three 8-bit channels.
  function automatic rgb_t expand_pix(input logic [2:0] fmt, input logic [PAIR_W-1:0] v);
    rgb_t c;
    case (fmt)
      FMT_444: begin
        c.r = {v[11:8], 4'b0};
        c.g = {v[7:4],  4'b0};
        c.b = {v[3:0],  4'b0};
      end
      FMT_555: begin
        c.r = {v[14:10], 3'b0};
        c.g = {v[9:5],   3'b0};
        c.b = {v[4:0],   3'b0};
      end
      default: begin
        c.r = {v[15:11], 3'b0};
        c.g = {v[10:5],  2'b0};
        c.b = {v[4:0],   3'b0};
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pcap_byte_pair.sv
module pcap_byte_pair
  import pcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              href,
  input  logic [BYTE_W-1:0] din,
  output logic              pair_done,
  output logic [PAIR_W-1:0] pair_val,
  output logic              line_end
);

  logic              href_q, href_q_n;
  logic              have_hi, have_hi_n;
  logic [BYTE_W-1:0] hi_q, hi_q_n;
  logic              hi_en;

  always_comb begin
    href_q_n = href;
    have_hi_n = 1'b0;
    hi_en = 1'b0;
    hi_q_n = hi_q;
    if (href) begin
      if (!href_q || !have_hi) begin
        have_hi_n = 1'b1;
        hi_en = 1'b1;
        hi_q_n = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      href_q  <= 1'b0;
      have_hi <= 1'b0;
      hi_q    <= '0;
    end else begin
      href_q  <= href_q_n;
      have_hi <= have_hi_n;
      if (hi_en) hi_q <= hi_q_n;
    end
  end

  assign pair_done = href & href_q & have_hi;
  assign pair_val  = {hi_q, din};
  assign line_end  = href_q & ~href;

endmodule

// File: rtl/pcap_fmt_expand.sv
module pcap_fmt_expand
  import pcap_pkg::*;
(
  input  logic [2:0]        fmt,
  input  logic [PAIR_W-1:0] packed_pix,
  output logic [WORD_W-1:0] word
);

  localparam int PAD_W = WORD_W - 3 * CH_W;

  rgb_t c;

  always_comb begin
    c = expand_pix(fmt, packed_pix);
    word = {{PAD_W{1'b0}}, c};
  end

endmodule

// File: rtl/pcap_marker.sv
module pcap_marker
  import pcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              pix_in_vld,
  input  logic [WORD_W-1:0] pix_in,
  input  logic              line_end,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sof,
  output logic              out_eol
);

  logic              vs_q;
  logic              sof_pend, sof_pend_n;
  logic              held_vld, held_vld_n;
  logic              held_sof, held_sof_n;
  logic [WORD_W-1:0] held_word, held_word_n;
  logic              out_vld_n, out_sof_n, out_eol_n;
  logic [WORD_W-1:0] out_word_n;
  logic              sof_now;

  always_comb begin
    sof_now     = sof_pend | (vs_q & ~vsync);
    sof_pend_n  = sof_now;
    held_vld_n  = held_vld;
    held_sof_n  = held_sof;
    held_word_n = held_word;
    out_vld_n   = 1'b0;
    out_sof_n   = 1'b0;
    out_eol_n   = 1'b0;
    out_word_n  = out_word;
    if (pix_in_vld) begin
      if (held_vld) begin
        out_vld_n  = 1'b1;
        out_sof_n  = held_sof;
        out_word_n = held_word;
      end
      held_vld_n  = 1'b1;
      held_sof_n  = sof_now;
      held_word_n = pix_in;
      sof_pend_n  = 1'b0;
    end else if (line_end) begin
      if (held_vld) begin
        out_vld_n  = 1'b1;
        out_sof_n  = held_sof;
        out_eol_n  = 1'b1;
        out_word_n = held_word;
      end
      held_vld_n = 1'b0;
      held_sof_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q      <= 1'b0;
      sof_pend  <= 1'b0;
      held_vld  <= 1'b0;
      held_sof  <= 1'b0;
      held_word <= '0;
      out_vld   <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_word  <= '0;
    end else begin
      vs_q      <= vsync;
      sof_pend  <= sof_pend_n;
      held_vld  <= held_vld_n;
      held_sof  <= held_sof_n;
      if (pix_in_vld) held_word <= held_word_n;
      out_vld   <= out_vld_n;
      out_sof   <= out_sof_n;
      out_eol   <= out_eol_n;
      if (out_vld_n) out_word <= out_word_n;
    end
  end

endmodule

// File: rtl/cam_pix_capture.sv
module cam_pix_capture
  import pcap_pkg::*;
(
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              href,
  input  logic [BYTE_W-1:0] cam_d,
  input  logic [2:0]        fmt_sel,
  output logic [WORD_W-1:0] pix_word,
  output logic              pix_valid,
  output logic              pix_sof,
  output logic              pix_eol
);

  logic              pair_done;
  logic [PAIR_W-1:0] pair_val;
  logic              line_end;
  logic [WORD_W-1:0] exp_word;

  pcap_byte_pair u_pair (
    .clk       (pclk),
    .rst_n     (rst_n),
    .href      (href),
    .din       (cam_d),
    .pair_done (pair_done),
    .pair_val  (pair_val),
    .line_end  (line_end)
  );

  pcap_fmt_expand u_expand (
    .fmt        (fmt_sel),
    .packed_pix (pair_val),
    .word       (exp_word)
  );

  pcap_marker u_mark (
    .clk        (pclk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .pix_in_vld (pair_done),
    .pix_in     (exp_word),
    .line_end   (line_end),
    .out_vld    (pix_valid),
    .out_word   (pix_word),
    .out_sof    (pix_sof),
    .out_eol    (pix_eol)
  );

endmodule

// File: rtl/cam_pix_capture_chk.sv
module cam_pix_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        href,
  input logic [31:0] pix_word,
  input logic        pix_valid,
  input logic        pix_sof,
  input logic        pix_eol
);

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (pix_word[31:24] == 8'h00));

  // R11
  marker_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_sof || pix_eol) |-> pix_valid);

  // R8
  eol_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> (!$past(href) && $past(href, 2)));

  // R9
  mid_line_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_eol) |-> ($past(href) && $past(href, 2)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!pix_valid && !pix_sof && !pix_eol));

endmodule

bind cam_pix_capture cam_pix_capture_chk u_chk (
  .clk       (pclk),
  .rst_n     (rst_n),
  .href      (href),
  .pix_word  (pix_word),
  .pix_valid (pix_valid),
  .pix_sof   (pix_sof),
  .pix_eol   (pix_eol)
);

// File: tb/test_cam_pix_capture.sv
module test_cam_pix_capture;

  logic        clk;
  logic        rst_n;
  logic        vsync;
  logic        href;
  logic [7:0]  cam_d;
  logic [2:0]  fmt_sel;
  logic [31:0] pix_word;
  logic        pix_valid;
  logic        pix_sof;
  logic        pix_eol;

  cam_pix_capture i_cam_pix_capture (
    .pclk(clk), .rst_n(rst_n), .vsync(vsync), .href(href), .cam_d(cam_d),
    .fmt_sel(fmt_sel), .pix_word(pix_word), .pix_valid(pix_valid),
    .pix_sof(pix_sof), .pix_eol(pix_eol)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  typedef struct {
    int          cyc;
    logic [31:0] w;
    bit          sof;
    bit          eol;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   sof_pend = 0;
  bit   done = 0;
  bit   reported = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, expv);
    end
  endtask

  // Reference expansion of a 16-bit value, worked from the layouts in R3/R4/R5.
  function automatic logic [31:0] ref_pix(input logic [2:0] f, input logic [7:0] hi, input logic [7:0] lo);
    int v, r, g, b;
    v = hi * 256 + lo;
    if (f == 3'b000) begin
      r = ((v / 256) % 16) * 16; g = ((v / 16) % 16) * 16; b = (v % 16) * 16;
    end else if (f == 3'b001) begin
      r = ((v / 1024) % 32) * 8; g = ((v / 32) % 32) * 8; b = (v % 32) * 8;
    end else begin
      r = ((v / 2048) % 32) * 8; g = ((v / 32) % 64) * 4; b = (v % 32) * 8;
    end
    return 32'(r * 65536 + g * 256 + b);
  endfunction

  function automatic string fmt_tag(input logic [2:0] f);
    if (f == 3'b000) return "R5";
    if (f == 3'b001) return "R4";
    return "R3";
  endfunction

  // Drive one line of nb bytes starting at the next edge, and predict its pixels.
  task automatic send_line(input int nb, input int seed, input int gap);
    int t0;
    int npix;
    logic [7:0] bq[$];
    for (int j = 0; j < nb; j++) bq.push_back(8'((seed * 13 + j * 71 + j * j * 5) % 256));
    @(negedge clk);
    t0 = cyc + 1;
    npix = nb / 2;
    for (int j = 0; j < nb; j++) begin
      href = 1'b1;
      cam_d = bq[j];
      if (j % 2 == 1) begin
        exp_t e;
        int k;
        k = (j - 1) / 2;
        e.w = ref_pix(fmt_sel, bq[j-1], bq[j]);
        e.sof = sof_pend;
        sof_pend = 0;
        e.eol = (k == npix - 1);
        e.cyc = e.eol ? (t0 + nb) : (t0 + 2 * k + 3);
        e.tag = fmt_tag(fmt_sel);
        expq.push_back(e);
      end
      @(negedge clk);
    end
    href = 1'b0;
    cam_d = 8'hA5;
    repeat (gap) @(negedge clk);
  endtask

  // R7: vsync pulse arms the start-of-frame marker for the next pixel.
  task automatic frame_pulse();
    @(negedge clk);
    vsync = 1'b1;
    repeat (3) @(negedge clk);
    vsync = 1'b0;
    repeat (2) @(negedge clk);
    sof_pend = 1;
  endtask

  // Per-cycle comparison against the predicted event list.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pix_valid) begin
        if (expq.size() == 0 || expq[0].cyc != cyc) begin
          chk(0, "R2/R9/R10 unexpected pixel", pix_word, 32'h0);
        end else begin
          chk(pix_word == expq[0].w, expq[0].tag, pix_word, expq[0].w);
          chk(pix_word[31:24] == 8'h00, "R6", {24'h0, pix_word[31:24]}, 32'h0);
          chk(pix_sof == expq[0].sof, "R7", {31'h0, pix_sof}, {31'h0, expq[0].sof});
          chk(pix_eol == expq[0].eol, "R8", {31'h0, pix_eol}, {31'h0, expq[0].eol});
          void'(expq.pop_front());
        end
      end else begin
        if (pix_sof || pix_eol) chk(0, "R11", {30'h0, pix_sof, pix_eol}, 32'h0);
        if (expq.size() != 0 && expq[0].cyc == cyc) begin
          chk(0, "R9 missing pixel", 32'h0, expq[0].w);
          void'(expq.pop_front());
        end
      end
    end
  end

  initial begin
    #2ms;
    if (!reported) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
      report();
    end
  end

  initial begin
    rst_n = 1'b0; vsync = 1'b0; href = 1'b0; cam_d = 8'h00; fmt_sel = 3'b010;
    repeat (3) @(negedge clk);
    href = 1'b1; cam_d = 8'hFF;
    @(negedge clk);
    // R1: outputs quiet under reset even with active inputs
    chk({pix_valid, pix_sof, pix_eol} == 3'b000 && pix_word == 32'h0, "R1",
        {28'h0, pix_valid, pix_sof, pix_eol, 1'b0}, 32'h0);
    href = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: no marker before any vsync pulse; R3 5:6:5
    send_line(8, 1, 4);
    frame_pulse();
    send_line(10, 2, 3);
    send_line(6, 3, 2);
    // R4 5:5:5, seeds chosen so bit 15 toggles
    fmt_sel = 3'b001;
    send_line(12, 20, 3);
    send_line(8, 77, 1);
    // R5 4:4:4, upper nibble of first byte is non-zero
    fmt_sel = 3'b000;
    frame_pulse();
    send_line(8, 5, 3);
    send_line(14, 91, 2);
    // R3: reserved codes behave as 5:6:5
    fmt_sel = 3'b110;
    send_line(6, 40, 2);
    fmt_sel = 3'b011;
    send_line(4, 41, 2);
    // R10: odd lengths and single byte lines
    fmt_sel = 3'b010;
    send_line(1, 9, 3);
    send_line(3, 10, 2);
    send_line(5, 11, 1);
    send_line(4, 12, 2);
    // R8/R7: a two-byte line carries both markers
    frame_pulse();
    send_line(2, 13, 3);
    send_line(2, 14, 3);
    fmt_sel = 3'b001;
    send_line(7, 15, 4);

    repeat (10) @(negedge clk);
    done = 1;
    // R9: every predicted pixel was produced
    chk(expq.size() == 0, "R9 pending pixels", 32'(expq.size()), 32'h0);
    report();
  end

endmodule